// File: doc/BRIEF.md
# Last Reset Cause Register

This block records why the system went through its most recent reset and presents that reason as a row of one-hot flags. A set of external cause strobes (auxiliary power loss, thermal trip, watchdogs, firmware and software resets, supply failures and so on) arrives from cause-generation logic elsewhere on the chip. A raw power-button level also arrives, and the block itself sorts each press into a short or a long press. When any strobe fires, the register is overwritten so that only the newest cause is flagged. All earlier history is dropped.

The flags sit in the always-on domain. They are cleared only by the cold power-on reset, which leaves the auxiliary-power flag set. The block has no system-reset input, so the reset it records cannot erase it. Software reads the flags through a word-wide register port that has no write path. The full vector is also given to neighbouring logic.

The button classifier is a three-state machine:
- `BTN_IDLE` waits for the button. It moves to `BTN_SHORT` on the first sampled high.
- `BTN_SHORT` counts held cycles. On release it goes back to `BTN_IDLE` and reports a short press. Once the count reaches `LONG_CYCLES` while the button is still held, it moves to `BTN_LONG`.
- `BTN_LONG` waits for release. On release it goes back to `BTN_IDLE` and reports a long press.

Top module: `lrc_last_reset_cause`

## Requirements
- R1: Flag index 0 means auxiliary power loss. Indices 1 to NUM_EXT-1 follow `ext_cause_i` bit for bit. Index NUM_EXT means short button press, and index NUM_EXT+1 means long button press. A 1 marks the recorded cause.
- R2: While `por_n` is high, exactly one flag is 1 at every cycle.
- R3: While `por_n` is low, the flags read as only index 0 set, whether the reset comes at start-up or later in a run.
- R4: A strobe on `ext_cause_i[i]` sampled at a clock edge replaces the flags at that edge with only index i. The previous cause is discarded.
- R5: When no strobe and no button press report arrive, the flags keep their value.
- R6: When several causes are presented at the same edge, the lowest index is recorded.
- R7: Suppose the button is sampled high on H consecutive edges and then low. If H ≤ LONG_CYCLES, index NUM_EXT is recorded. If H > LONG_CYCLES, index NUM_EXT+1 is recorded. The flags change on the second edge after the first low sample.
- R8: While the button stays held, however long, the flags do not change because of it.
- R9: `rd_data_o` returns flag bits [8*sel+7 : 8*sel] for `rd_sel_i` = sel. Bits above NUM_EXT+1, and selects of 3 or more, read 0.
- R10: Changing `rd_sel_i` has no effect on the flags. The port has no way to write them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Cold power-on reset, active low, asynchronous |
| ext_cause_i | input | NUM_EXT | One-cycle cause strobes; bit 0 is auxiliary power loss |
| btn_i | input | 1 | Power-button level, high while pressed |
| rd_sel_i | input | SEL_W | Word select of the read port |
| rd_data_o | output | WORD_W | Selected flag word |
| flags_o | output | NUM_EXT+2 | Full one-hot cause vector |

## Verification
The state that matters is the one-hot cause vector and the button classifier's state and counter. An error in the vector appears on `flags_o` in the cycle after the faulty update, as a second bit or the wrong index. An error in the classifier appears only when the button is released: the wrong press kind shows up two edges after the release. For this reason, press lengths are driven at and around the threshold. A reference model in the bench compares the vector and the read word on every cycle.

// File: rtl/lrc_pkg.sv
`timescale 1ns/1ps
package lrc_pkg;
    typedef enum logic [1:0] {
        BTN_IDLE  = 2'd0,
        BTN_SHORT = 2'd1,
        BTN_LONG  = 2'd2
    } btn_state_e;
endpackage

// File: rtl/lrc_btn_classifier.sv
`timescale 1ns/1ps
module lrc_btn_classifier
    import lrc_pkg::*;
#(
    parameter int LONG_CYCLES = 1000
) (
    input  logic clk,
    input  logic por_n,
    input  logic btn_i,
    output logic short_evt_o,
    output logic long_evt_o
);
    localparam int CNT_W = $clog2(LONG_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LONG_CYCLES);

    btn_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= BTN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BTN_IDLE: begin
                if (btn_i) begin
                    state_d = BTN_SHORT;
                    cnt_d   = CNT_W'(1);
                end
            end
            BTN_SHORT: begin
                if (!btn_i) begin
                    state_d = BTN_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == LIMIT) begin
                    state_d = BTN_LONG;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            BTN_LONG: begin
                if (!btn_i) begin
                    state_d = BTN_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = BTN_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // registered press reports
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            short_evt_o <= 1'b0;
            long_evt_o  <= 1'b0;
        end else begin
            short_evt_o <= (state_q == BTN_SHORT) && !btn_i;
            long_evt_o  <= (state_q == BTN_LONG) && !btn_i;
        end
    end
endmodule

// File: rtl/lrc_cause_capture.sv
`timescale 1ns/1ps
module lrc_cause_capture #(
    parameter int N = 20
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] flags_o
);
    localparam logic [N-1:0] COLD_VAL = N'(1);

    logic [N-1:0] pick;
    assign pick = req_i & (~req_i + N'(1));

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            flags_o <= COLD_VAL;
        else if (|req_i)
            flags_o <= pick;
    end
endmodule

// File: rtl/lrc_read_port.sv
`timescale 1ns/1ps
module lrc_read_port #(
    parameter int N      = 20,
    parameter int WORD_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic [N-1:0]      flags_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [WORD_W-1:0] data_o
);
    localparam int NUM_WORDS = (N + WORD_W - 1) / WORD_W;
    localparam int PAD_W     = NUM_WORDS * WORD_W;

    logic [PAD_W-1:0]  padded;
    logic [WORD_W-1:0] word [NUM_WORDS];

    assign padded = PAD_W'(flags_i);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign word[w] = padded[w*WORD_W +: WORD_W];
    end

    always_comb begin
        data_o = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (sel_i == SEL_W'(w)) data_o = word[w];
        end
    end
endmodule

// File: rtl/lrc_last_reset_cause.sv
`timescale 1ns/1ps
module lrc_last_reset_cause #(
    parameter int NUM_EXT     = 18,
    parameter int LONG_CYCLES = 1000,
    parameter int WORD_W      = 8,
    localparam int NUM_CAUSES = NUM_EXT + 2,
    localparam int NUM_WORDS  = (NUM_CAUSES + WORD_W - 1) / WORD_W,
    localparam int SEL_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS + 1) : 1
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic [NUM_EXT-1:0]    ext_cause_i,
    input  logic                  btn_i,
    input  logic [SEL_W-1:0]      rd_sel_i,
    output logic [WORD_W-1:0]     rd_data_o,
    output logic [NUM_CAUSES-1:0] flags_o
);
    logic btn_short, btn_long;
    logic [NUM_CAUSES-1:0] req;

    lrc_btn_classifier #(.LONG_CYCLES(LONG_CYCLES)) u_btn (
        .clk        (clk),
        .por_n      (por_n),
        .btn_i      (btn_i),
        .short_evt_o(btn_short),
        .long_evt_o (btn_long)
    );

    assign req = {btn_long, btn_short, ext_cause_i};

    lrc_cause_capture #(.N(NUM_CAUSES)) u_cap (
        .clk    (clk),
        .por_n  (por_n),
        .req_i  (req),
        .flags_o(flags_o)
    );

    lrc_read_port #(.N(NUM_CAUSES), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_rd (
        .flags_i(flags_o),
        .sel_i  (rd_sel_i),
        .data_o (rd_data_o)
    );
endmodule

// File: rtl/lrc_checker.sv
`timescale 1ns/1ps
module lrc_checker #(
    parameter int NUM_EXT = 18
) (
    input logic                 clk,
    input logic                 por_n,
    input logic [NUM_EXT-1:0]   ext_cause,
    input logic                 short_evt,
    input logic                 long_evt,
    input logic [NUM_EXT+1:0]   flags
);
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!por_n)
        $countones(flags) == 1); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!por_n)
        (!(|ext_cause) && !short_evt && !long_evt) |=> $stable(flags)); // R5

    AST_AUX_WINS: assert property (@(posedge clk) disable iff (!por_n)
        ext_cause[0] |=> flags[0]); // R6

    AST_SHORT_REC: assert property (@(posedge clk) disable iff (!por_n)
        (short_evt && !(|ext_cause)) |=> flags[NUM_EXT]); // R7

    AST_LONG_REC: assert property (@(posedge clk) disable iff (!por_n)
        (long_evt && !(|ext_cause)) |=> flags[NUM_EXT+1]); // R7

    AST_PRESS_EXCL: assert property (@(posedge clk) disable iff (!por_n)
        !(short_evt && long_evt)); // R7
endmodule

bind lrc_last_reset_cause lrc_checker #(.NUM_EXT(NUM_EXT)) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .ext_cause(ext_cause_i),
    .short_evt(btn_short),
    .long_evt (btn_long),
    .flags    (flags_o)
);

// File: tb/lrc_last_reset_cause_bench.sv
`timescale 1ns/1ps
module lrc_last_reset_cause_bench;
    localparam int NE = 18;
    localparam int NC = NE + 2;
    localparam int LC = 6;
    localparam int SHORT_IDX = NE;
    localparam int LONG_IDX  = NE + 1;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic [NE-1:0] ext = '0;
    logic          btn = 1'b0;
    logic [1:0]    sel = '0;
    logic [7:0]    rd_data;
    logic [NC-1:0] flags;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    string phase = "R3";

    // behavioural model state
    int m_idx = 0;
    int m_held = 0;
    int m_pend = -1;

    always #5 clk = ~clk;

    lrc_last_reset_cause #(.NUM_EXT(NE), .LONG_CYCLES(LC), .WORD_W(8)) u_lrc_last_reset_cause (
        .clk        (clk),
        .por_n      (por_n),
        .ext_cause_i(ext),
        .btn_i      (btn),
        .rd_sel_i   (sel),
        .rd_data_o  (rd_data),
        .flags_o    (flags)
    );

    function automatic logic [NC-1:0] onehot(int i);
        logic [NC-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [7:0] exp_word(int idx, int s);
        logic [7:0] w;
        w = '0;
        if (s < 3 && idx / 8 == s) w[idx % 8] = 1'b1;
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model
    always @(posedge clk) begin
        cyc++;
        if (!por_n) begin
            m_idx = 0; m_held = 0; m_pend = -1;
        end else begin
            int win;
            win = -1;
            for (int i = 0; i < NE; i++) if (ext[i] && win < 0) win = i;
            if (win < 0 && m_pend >= 0) win = m_pend;
            if (win >= 0) m_idx = win;
            m_pend = -1;
            if (btn) m_held++;
            else if (m_held > 0) begin
                m_pend = (m_held > LC) ? LONG_IDX : SHORT_IDX;
                m_held = 0;
            end
        end
        if (cyc == 20000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cyc > 0) begin
            chk(phase, 32'(flags), 32'(onehot(m_idx)));
            if (por_n) chk("R2", 32'($countones(flags)), 32'd1);
            chk("R9", 32'(rd_data), 32'(exp_word(m_idx, int'(sel))));
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic pulse(logic [NE-1:0] v);
        @(negedge clk); #1 ext = v;
        @(negedge clk); #1 ext = '0;
    endtask

    task automatic press(int h);
        @(negedge clk); #1 btn = 1'b1;
        repeat (h) @(negedge clk);
        #1 btn = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R3", 32'(flags), 32'(onehot(0)));
        #1 por_n = 1'b1;

        phase = "R1";
        for (int i = 1; i < NE; i++) begin
            pulse(NE'(1) << i);
            chk("R1", 32'(flags), 32'(onehot(i)));
        end
        pulse(NE'(1));
        chk("R1", 32'(flags), 32'(onehot(0)));

        phase = "R4";
        pulse(NE'(1) << 5);
        chk("R4", 32'(flags), 32'(onehot(5)));
        pulse(NE'(1) << 11);
        chk("R4", 32'(flags), 32'(onehot(11)));

        phase = "R5";
        repeat (6) step();
        chk("R5", 32'(flags), 32'(onehot(11)));

        phase = "R6";
        pulse((NE'(1) << 7) | (NE'(1) << 12));
        chk("R6", 32'(flags), 32'(onehot(7)));
        pulse(NE'(1) | (NE'(1) << 17));
        chk("R6", 32'(flags), 32'(onehot(0)));

        phase = "R7";
        press(1);
        chk("R7", 32'(flags), 32'(onehot(SHORT_IDX)));
        pulse(NE'(1) << 4);
        press(LC);
        chk("R7", 32'(flags), 32'(onehot(SHORT_IDX)));
        press(LC + 1);
        chk("R7", 32'(flags), 32'(onehot(LONG_IDX)));
        press(3);
        chk("R7", 32'(flags), 32'(onehot(SHORT_IDX)));

        phase = "R8";
        pulse(NE'(1) << 9);
        @(negedge clk); #1 btn = 1'b1;
        repeat (25) @(negedge clk);
        chk("R8", 32'(flags), 32'(onehot(9)));
        #1 btn = 1'b0;
        @(negedge clk);
        chk("R8", 32'(flags), 32'(onehot(9)));
        @(negedge clk);
        chk("R8", 32'(flags), 32'(onehot(LONG_IDX)));

        phase = "R9";
        pulse(NE'(1) << 17);
        #1 sel = 2'd2;
        @(negedge clk);
        chk("R9", 32'(rd_data), 32'h02);
        #1 sel = 2'd0;
        @(negedge clk);
        chk("R9", 32'(rd_data), 32'h00);
        #1 sel = 2'd3;
        @(negedge clk);
        chk("R9", 32'(rd_data), 32'h00);

        phase = "R10";
        for (int s = 0; s < 4; s++) begin
            #1 sel = 2'(s);
            @(negedge clk);
        end
        chk("R10", 32'(flags), 32'(onehot(17)));

        phase = "R3";
        @(negedge clk); #1 btn = 1'b1;
        repeat (3) @(negedge clk);
        #1 por_n = 1'b0;
        @(negedge clk);
        chk("R3", 32'(flags), 32'(onehot(0)));
        #1 btn = 1'b0;
        @(negedge clk); #1 por_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R3", 32'(flags), 32'(onehot(0)));

        phase = "R4";
        pulse(NE'(1) << 2);
        chk("R4", 32'(flags), 32'(onehot(2)));
        repeat (3) step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule